// File: doc/BRIEF.md
# Event-Triggered Single-Move Channel

This block takes an interrupt request that has been steered away from the processor and, instead of a software handler running, copies one byte or one 16-bit word from a source address to a destination address inside a 64 KB space. Software loads the channel once with both pointers, the transfer size, the pointer-advance mode and a transfer count. Each later trigger then costs the processor exactly one bus cycle. The channel asks for the bus and waits for the grant. In the granted cycle it reads and writes through a combined read/write port and clears the trigger. It then advances at most one of its two pointers.

The count tracks how many moves remain. When a trigger arrives while the count is zero, the channel moves nothing and forwards the trigger to the processor as an ordinary interrupt request. The all-ones count value selects endless operation, and that value is never decremented.

Top module: `evm_chan`

## Requirements
- R1: A trigger seen while idle with a nonzero count causes exactly one read strobe and one write strobe (`mem_re_o`, `mem_we_o`). Both occur in the cycle where `bus_gnt_i` is high during a pending request, and never in any other cycle.
- R2: `bus_req_o` rises in the cycle after the trigger is sampled. It stays high through every cycle without grant, including the grant cycle, and is low in the following cycle.
- R3: `trig_clr_o` is high only in the grant cycle of a move, so a trigger source that clears on it is low from the next cycle on.
- R4: Word mode (`cfg_wide_i`=1) forces bit 0 of the read and write addresses to 0, drives `mem_be_o`=2'b11 and copies the full 16-bit read word unchanged.
- R5: Byte mode (`cfg_wide_i`=0) takes the source byte from bits 15:8 when source bit 0 is 1, and from bits 7:0 otherwise. It places that byte on both halves of `mem_wdata_o` and enables only lane 1 (`mem_be_o`=2'b10) when destination bit 0 is 1, or only lane 0 (2'b01) when it is 0.
- R6: The advance field `cfg_inc_i` uses 2'b00 for none, 2'b01 for the source pointer only, 2'b10 for the destination pointer only and 2'b11 for none. The step is 1 in byte mode and 2 in word mode. The pointer wraps modulo 2^16, and the two pointers never both change on one move.
- R7: After each move the count drops by one, except when it holds 8'hFF, in which case it stays 8'hFF.
- R8: While the count is zero and the trigger is high, `cpu_irq_o` is high. No bus request, strobe or trigger clear occurs, and memory is untouched.
- R9: A configuration load (`cfg_ld_i`) takes effect at the next edge only when no request is pending. While a request waits for its grant, the load is ignored and the pointers and count are unchanged.
- R10: During and right after reset, the pointers, count, bus request, strobes, trigger clear and `cpu_irq_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Interrupt request routed to this channel |
| trig_clr_o | output | 1 | Clears the routed request in the move cycle |
| cpu_irq_o | output | 1 | Request passed on to the processor when the count is exhausted |
| cfg_ld_i | input | 1 | Loads pointers, count, size and advance mode |
| cfg_src_i | input | 16 | Source pointer load value |
| cfg_dst_i | input | 16 | Destination pointer load value |
| cfg_cnt_i | input | 8 | Count load value (8'hFF endless) |
| cfg_wide_i | input | 1 | 1 word, 0 byte |
| cfg_inc_i | input | 2 | Pointer advance mode |
| src_ptr_o | output | 16 | Current source pointer |
| dst_ptr_o | output | 16 | Current destination pointer |
| cnt_o | output | 8 | Current count |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_gnt_i | input | 1 | One-cycle bus grant |
| mem_raddr_o | output | 16 | Read address |
| mem_waddr_o | output | 16 | Write address |
| mem_rdata_i | input | 16 | Read data, valid in the same cycle |
| mem_wdata_o | output | 16 | Write data |
| mem_be_o | output | 2 | Byte-lane write enables |
| mem_re_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe |

## Verification
A stuck or wrongly entered sequencer state shows at the ports one cycle later. It appears as `bus_req_o` held with no trigger, as a second strobe for one trigger, or as a trigger that is never cleared. A wrong pointer or count register appears on `src_ptr_o`, `dst_ptr_o` or `cnt_o` in the cycle after the move. It then spreads into the addresses and lane enables of the next move, so the bench compares those outputs after each move. A mis-steered byte lane shows up only in memory contents, so the destination word is read back from the bench memory after every move.

// File: rtl/evm_pkg.sv
package evm_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ADV_NONE = 2'b00,
    ADV_SRC  = 2'b01,
    ADV_DST  = 2'b10,
    ADV_RSVD = 2'b11
  } adv_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } sq_e;
endpackage

// File: rtl/evm_seq.sv
module evm_seq
  import evm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic cnt_zero_i,
  input  logic gnt_i,
  output logic busy_o,
  output logic req_o,
  output logic move_o,
  output logic clr_o
);
  sq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_IDLE: if (trig_i && !cnt_zero_i) st_d = SQ_WAIT;
      SQ_WAIT: if (gnt_i)                 st_d = SQ_IDLE;
      default:                            st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign busy_o = (st_q == SQ_WAIT);
  assign req_o  = busy_o;
  assign move_o = busy_o && gnt_i;
  assign clr_o  = move_o;

  // R2: a request not yet granted is held
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> req_o);
  // R2: a granted request is released
  a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> !req_o);
  // R3: trigger clear only alongside a grant
  a_r3_clr_granted: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> gnt_i);
endmodule

// File: rtl/evm_regs.sv
module evm_regs
  import evm_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_i,
  input  logic          busy_i,
  input  logic          move_i,
  input  logic [AW-1:0] src_ld_i,
  input  logic [AW-1:0] dst_ld_i,
  input  logic [CW-1:0] cnt_ld_i,
  input  logic          wide_ld_i,
  input  logic [1:0]    adv_ld_i,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [CW-1:0] cnt_q,
  output logic          wide_q,
  output adv_e          adv_q,
  output logic          cnt_zero_o
);
  localparam logic [CW-1:0] CNT_ENDLESS = '1;

  logic [AW-1:0] src_d, dst_d, step;
  logic [CW-1:0] cnt_d;
  logic          wide_d;
  adv_e          adv_d;
  logic          ld_ok, en;

  assign ld_ok = ld_i && !busy_i;
  assign en    = ld_ok || move_i;
  assign step  = wide_q ? AW'(2) : AW'(1);

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    cnt_d  = cnt_q;
    wide_d = wide_q;
    adv_d  = adv_q;
    if (ld_ok) begin
      src_d  = src_ld_i;
      dst_d  = dst_ld_i;
      cnt_d  = cnt_ld_i;
      wide_d = wide_ld_i;
      adv_d  = adv_e'(adv_ld_i);
    end else if (move_i) begin
      if (adv_q == ADV_SRC) src_d = src_q + step;
      if (adv_q == ADV_DST) dst_d = dst_q + step;
      if (cnt_q != CNT_ENDLESS) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      wide_q <= 1'b0;
      adv_q  <= ADV_NONE;
    end else if (en) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      cnt_q  <= cnt_d;
      wide_q <= wide_d;
      adv_q  <= adv_d;
    end
  end

  assign cnt_zero_o = (cnt_q == '0);

  // R6: one move never advances both pointers
  a_r6_single_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    move_i |=> ($stable(src_q) || $stable(dst_q)));
  // R7: endless count survives a move
  a_r7_endless: assert property (@(posedge clk) disable iff (!rst_n)
    (move_i && cnt_q == CNT_ENDLESS) |=> (cnt_q == CNT_ENDLESS));
  // R7: finite count drops by one
  a_r7_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (move_i && cnt_q != CNT_ENDLESS) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R9: load while waiting has no effect
  a_r9_ld_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !move_i) |=> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));
endmodule

// File: rtl/evm_lane.sv
module evm_lane
  import evm_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]     src_i,
  input  logic [AW-1:0]     dst_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [AW-1:0]     raddr_o,
  output logic [AW-1:0]     waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [LANES-1:0]  be_o
);
  logic [7:0] pick;

  assign raddr_o = wide_i ? {src_i[AW-1:1], 1'b0} : src_i;
  assign waddr_o = wide_i ? {dst_i[AW-1:1], 1'b0} : dst_i;
  assign pick    = src_i[0] ? rdata_i[15:8] : rdata_i[7:0];

  always_comb begin
    if (wide_i) begin
      wdata_o = rdata_i;
      be_o    = '1;
    end else begin
      wdata_o = {pick, pick};
      be_o    = dst_i[0] ? 2'b10 : 2'b01;
    end
  end
endmodule

// File: rtl/evm_chan.sv
module evm_chan
  import evm_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  output logic          trig_clr_o,
  output logic          cpu_irq_o,
  input  logic          cfg_ld_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [CW-1:0] cfg_cnt_i,
  input  logic          cfg_wide_i,
  input  logic [1:0]    cfg_inc_i,
  output logic [AW-1:0] src_ptr_o,
  output logic [AW-1:0] dst_ptr_o,
  output logic [CW-1:0] cnt_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic [AW-1:0] mem_raddr_o,
  output logic [AW-1:0] mem_waddr_o,
  input  logic [15:0]   mem_rdata_i,
  output logic [15:0]   mem_wdata_o,
  output logic [1:0]    mem_be_o,
  output logic          mem_re_o,
  output logic          mem_we_o
);
  logic [1:0] rsync_q;
  logic       rst_sn;
  logic       busy, move, cnt_zero, wide_q;
  adv_e       adv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  evm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .trig_i    (trig_i),
    .cnt_zero_i(cnt_zero),
    .gnt_i     (bus_gnt_i),
    .busy_o    (busy),
    .req_o     (bus_req_o),
    .move_o    (move),
    .clr_o     (trig_clr_o)
  );

  evm_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ld_i      (cfg_ld_i),
    .busy_i    (busy),
    .move_i    (move),
    .src_ld_i  (cfg_src_i),
    .dst_ld_i  (cfg_dst_i),
    .cnt_ld_i  (cfg_cnt_i),
    .wide_ld_i (cfg_wide_i),
    .adv_ld_i  (cfg_inc_i),
    .src_q     (src_ptr_o),
    .dst_q     (dst_ptr_o),
    .cnt_q     (cnt_o),
    .wide_q    (wide_q),
    .adv_q     (adv_q),
    .cnt_zero_o(cnt_zero)
  );

  evm_lane #(.AW(AW)) u_lane (
    .src_i  (src_ptr_o),
    .dst_i  (dst_ptr_o),
    .wide_i (wide_q),
    .rdata_i(mem_rdata_i),
    .raddr_o(mem_raddr_o),
    .waddr_o(mem_waddr_o),
    .wdata_o(mem_wdata_o),
    .be_o   (mem_be_o)
  );

  assign mem_re_o  = move;
  assign mem_we_o  = move;
  assign cpu_irq_o = trig_i && cnt_zero && !busy;

  // R1: strobes only inside a granted request
  a_r1_strobe_granted: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_we_o |-> (bus_req_o && bus_gnt_i));
  // R5: byte move enables a single lane
  a_r5_byte_lane: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_we_o && !wide_q) |-> ($countones(mem_be_o) == 1));
  // R8: forwarded request never comes with a strobe next cycle
  a_r8_no_move: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_irq_o && trig_i) |=> !mem_we_o);
  // R10: quiet bus right out of reset
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(rst_sn) |-> (!bus_req_o && !mem_we_o));
endmodule

// File: tb/sim_evm_chan.sv
module sim_evm_chan;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_q, trig_set, trig_kill;
  logic        trig_clr, cpu_irq;
  logic        cfg_ld, cfg_wide;
  logic [15:0] cfg_src, cfg_dst;
  logic [7:0]  cfg_cnt;
  logic [1:0]  cfg_inc;
  logic [15:0] src_o, dst_o, raddr, waddr, rdata, wdata;
  logic [7:0]  cnt_o;
  logic        req, gnt, re, we;
  logic [1:0]  be;
  logic [15:0] mem [256];
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  evm_chan u0 (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_q), .trig_clr_o(trig_clr),
    .cpu_irq_o(cpu_irq), .cfg_ld_i(cfg_ld), .cfg_src_i(cfg_src),
    .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt), .cfg_wide_i(cfg_wide),
    .cfg_inc_i(cfg_inc), .src_ptr_o(src_o), .dst_ptr_o(dst_o),
    .cnt_o(cnt_o), .bus_req_o(req), .bus_gnt_i(gnt),
    .mem_raddr_o(raddr), .mem_waddr_o(waddr), .mem_rdata_i(rdata),
    .mem_wdata_o(wdata), .mem_be_o(be), .mem_re_o(re), .mem_we_o(we)
  );

  // trigger source: set by the bench, cleared by the channel
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= (trig_q | trig_set) & ~trig_clr & ~trig_kill;
  end

  // memory model
  assign rdata = mem[raddr[8:1]];
  always @(posedge clk) begin
    if (we) begin
      if (be[0]) mem[waddr[8:1]][7:0]  <= wdata[7:0];
      if (be[1]) mem[waddr[8:1]][15:8] <= wdata[15:8];
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] s, input logic [15:0] d, input logic w,
                      input logic [1:0] a, input logic [7:0] c);
    @(negedge clk);
    cfg_src = s; cfg_dst = d; cfg_wide = w; cfg_inc = a; cfg_cnt = c; cfg_ld = 1'b1;
    @(negedge clk);
    cfg_ld = 1'b0;
  endtask

  task automatic fire;
    @(negedge clk); trig_set = 1'b1;
    @(negedge clk); trig_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_move(input logic [15:0] s, input logic [15:0] d, input logic w,
                          input logic [1:0] a, input logic [7:0] c, input int dly);
    logic [15:0] sw, dw, ew, es, ed, step, er, ewa;
    logic [7:0]  b, ec;
    logic [1:0]  eb;
    load(s, d, w, a, c);
    sw = mem[s[8:1]]; dw = mem[d[8:1]];
    b  = s[0] ? sw[15:8] : sw[7:0];
    if (w) begin ew = sw; eb = 2'b11; er = {s[15:1], 1'b0}; ewa = {d[15:1], 1'b0}; end
    else begin
      ew = d[0] ? {b, dw[7:0]} : {dw[15:8], b};
      eb = d[0] ? 2'b10 : 2'b01; er = s; ewa = d;
    end
    step = w ? 16'd2 : 16'd1;
    es = (a == 2'b01) ? s + step : s;
    ed = (a == 2'b10) ? d + step : d;
    ec = (c == 8'hFF) ? c : c - 8'd1;
    fire();
    for (int k = 0; k < dly; k++) begin
      chk(req === 1'b1, "R2 req held while waiting", req, 1);
      chk(we === 1'b0 && re === 1'b0, "R1 no strobe before grant", we, 0);
      @(negedge clk);
    end
    chk(req === 1'b1, "R2 req up at grant", req, 1);
    gnt = 1'b1; #1;
    chk(we === 1'b1 && re === 1'b1, "R1 strobes in grant cycle", we, 1);
    chk(trig_clr === 1'b1, "R3 clear in grant cycle", trig_clr, 1);
    chk(raddr === er, "R4/R5 read address", raddr, er);
    chk(waddr === ewa, "R4/R5 write address", waddr, ewa);
    chk(be === eb, "R4/R5 lane enables", be, eb);
    @(negedge clk); gnt = 1'b0;
    chk(req === 1'b0 && we === 1'b0, "R2 req dropped after grant", req, 0);
    chk(trig_q === 1'b0, "R3 trigger cleared", trig_q, 0);
    chk(mem[d[8:1]] === ew, "R4/R5 destination data", mem[d[8:1]], ew);
    chk(src_o === es, "R6 source pointer", src_o, es);
    chk(dst_o === ed, "R6 destination pointer", dst_o, ed);
    chk(cnt_o === ec, "R7 count", cnt_o, ec);
    @(negedge clk);
    chk(we === 1'b0 && trig_clr === 1'b0, "R1 single move per trigger", we, 0);
  endtask

  // {src, dst, wide, adv, count}
  localparam logic [42:0] VEC [8] = '{
    {16'h0010, 16'h0100, 1'b1, 2'b01, 8'h05},
    {16'h0021, 16'h0104, 1'b0, 2'b10, 8'h03},
    {16'h0030, 16'h0107, 1'b0, 2'b00, 8'hFF},
    {16'h0041, 16'h0109, 1'b1, 2'b10, 8'h01},
    {16'h0050, 16'h010C, 1'b1, 2'b11, 8'h02},
    {16'h00FF, 16'h0111, 1'b0, 2'b01, 8'h10},
    {16'hFFFE, 16'h0114, 1'b1, 2'b01, 8'hFF},
    {16'h0060, 16'h0116, 1'b0, 2'b10, 8'h80}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h5A, 8'(i)};
    rst_n = 1'b0; trig_set = 0; trig_kill = 0; gnt = 0; cfg_ld = 0;
    cfg_src = '0; cfg_dst = '0; cfg_cnt = '0; cfg_wide = 0; cfg_inc = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(src_o === 0 && dst_o === 0, "R10 pointers in reset", src_o, 0);
    chk(cnt_o === 0, "R10 count in reset", cnt_o, 0);
    chk(req === 0 && we === 0 && re === 0, "R10 bus idle in reset", req, 0);
    chk(cpu_irq === 0 && trig_clr === 0, "R10 irq and clear low", cpu_irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req === 0 && cnt_o === 0, "R10 idle after release", req, 0);

    for (int v = 0; v < 8; v++)
      run_move(VEC[v][42:27], VEC[v][26:11], VEC[v][10], VEC[v][9:8], VEC[v][7:0], v % 4);

    // R9: load ignored while waiting for grant
    load(16'h0070, 16'h0120, 1'b1, 2'b01, 8'h03);
    fire();
    cfg_src = 16'h0AAA; cfg_dst = 16'h0BBB; cfg_cnt = 8'h44; cfg_ld = 1'b1;
    @(negedge clk); cfg_ld = 1'b0;
    chk(src_o === 16'h0070 && dst_o === 16'h0120, "R9 pointers kept", src_o, 16'h0070);
    chk(cnt_o === 8'h03, "R9 count kept", cnt_o, 3);
    gnt = 1'b1; @(negedge clk); gnt = 1'b0;
    chk(src_o === 16'h0072 && cnt_o === 8'h02, "R9 move used old config", src_o, 16'h0072);

    // R8: exhausted count forwards the trigger
    run_move(16'h0080, 16'h0130, 1'b1, 2'b00, 8'h01, 1);
    begin
      logic [15:0] keep;
      keep = mem[8'h98];
      fire();
      chk(cpu_irq === 1'b1, "R8 irq forwarded", cpu_irq, 1);
      for (int k = 0; k < 3; k++) begin
        chk(req === 0 && we === 0 && trig_clr === 0, "R8 no bus activity", req, 0);
        @(negedge clk);
      end
      chk(trig_q === 1'b1, "R8 trigger left pending", trig_q, 1);
      chk(mem[8'h98] === keep, "R8 memory untouched", mem[8'h98], keep);
      trig_kill = 1'b1; @(negedge clk); trig_kill = 1'b0; #1;
      chk(cpu_irq === 1'b0, "R8 irq follows trigger", cpu_irq, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule